// File: doc/BRIEF.md
# I2C Register Control Port

This block is an I2C target that gives a two-wire controller access to a small bank of 8-bit control registers. The block takes SCL and SDA from inputs that are already synchronised to the system clock. It drives SDA only through an open-drain pull-down enable. The controller first sends an address byte. For a write, the next byte loads an internal pointer, and every byte after that lands in the register the pointer selects. For a read, data starts to flow straight after the address acknowledge, taken from wherever the pointer currently sits.

The top bit of the pointer byte chooses between two behaviours. In one, the pointer steps forward after every byte, so a single transfer streams through a block of registers. In the other, the pointer stays on one register. A strap pin supplies the lowest bit of the target address. If that pin ever falls after reset, a sticky flag takes the port off the I2C bus for good, because the pin then serves as the select line of a serial peripheral interface. Every register write is also shown on a strobe, index and data output, so the rest of the chip can follow the contents.

Top module: `i2c_regport`

## Requirements
- R1: The port acknowledges an address byte only when its upper seven bits equal binary 001100 followed by the current strap level. Bit 0 of the address byte is R/W, with 1 meaning read. On a mismatch, SDA stays released and every byte is ignored until the next START or STOP.
- R2: In a write, the first byte after the address acknowledge loads the pointer. Bit 7 of that byte is the increment flag and bits 6:0 are the register index. The byte is acknowledged.
- R3: Each further write byte is acknowledged and stored in the register at the pointer index. The write appears as a one-cycle `wr_stb_o` pulse carrying that index and data, raised while SCL is still high after the byte's eighth rising edge.
- R4: With the increment flag set, the pointer index advances by one after each byte written. With the flag clear, the pointer does not move.
- R5: After reset, the pointer is 0x00 and every register reads 0x00. A read starts sending the register at the current pointer right after the address acknowledge, MSB first.
- R6: During a read, the port keeps sending registers for as long as the controller acknowledges each byte. The pointer advances after each byte sent when the increment flag is set. A not-acknowledge ends the transfer.
- R7: An index of 16 or more reads as 0x00. A write to such an index is discarded and produces no strobe, but the pointer still advances.
- R8: A repeated START at any point aborts the current byte and restarts address matching. The pointer keeps its value.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data is sampled on the rising edge of SCL. The SDA enable changes only while SCL is low.
- R10: A falling edge on the strap pin after reset sets `spi_mode_o`, which then stays set until reset. While it is set, the port never pulls SDA low and never writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level |
| strap_i | input | 1 | Address strap pin, also serves as the chip select |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| spi_mode_o | output | 1 | Sticky flag showing the port has left I2C |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_idx_o | output | 7 | Index of the register being written |
| wr_data_o | output | 8 | Data being written |

## Verification
The assertions check four rules on every cycle. The SDA enable moves only while SCL is low. A write strobe lasts one cycle, falls while SCL is high and always targets an index inside the bank. Once the serial-peripheral flag is set, it stays set and keeps the port silent. Only the bench's transfers can show that data lands in the right place: address matching against the strap, the pointer stepping or staying put, defaults seen on the first read, discarded writes past the bank edge, and pointer preservation across an aborted byte. It checks these by reading the registers back over the bus and comparing them with a model.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int PTR_W = 8;
    localparam int IDX_W = PTR_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_TXLOAD
    } port_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        port_state_e        st;
        byte_kind_e         kind;
        logic [2:0]         cnt;
        logic [7:0]         sh;
        logic               rw;
        logic               oe;
        logic [PTR_W-1:0]   ptr;
        logic               wr_stb;
        logic [IDX_W-1:0]   wr_idx;
        logic [7:0]         wr_data;
    } port_regs_t;

endpackage

// File: rtl/i2c_regport_cond.sv
module i2c_regport_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = !scl_q && scl_i;
        scl_fall_o = scl_q && !scl_i;
        start_o    = scl_q && scl_i && sda_q && !sda_i;
        stop_o     = scl_q && scl_i && !sda_q && sda_i;
    end
endmodule

// File: rtl/i2c_regport_modelatch.sv
module i2c_regport_modelatch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic spi_mode_o
);
    logic strap_q, spi_q;
    logic spi_d;

    always_comb begin
        spi_d = spi_q || (strap_q && !strap_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= 1'b0;
            spi_q   <= 1'b0;
        end else begin
            strap_q <= strap_i;
            spi_q   <= spi_d;
        end
    end

    assign spi_mode_o = spi_q;
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
    parameter int         REG_COUNT = 16,
    parameter logic [7:0] RST_VAL   = 8'h00
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [i2c_regport_pkg::IDX_W-1:0]  widx_i,
    input  logic [7:0]                         wdata_i,
    input  logic [i2c_regport_pkg::IDX_W-1:0]  ridx_i,
    output logic [7:0]                         rdata_o
);
    localparam int FLAT_W = REG_COUNT * 8;

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_ent
        logic [7:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= RST_VAL;
            end else if (we_i && (widx_i == i2c_regport_pkg::IDX_W'(g))) begin
                ent_q <= wdata_i;
            end
        end
        assign flat[g*8 +: 8] = ent_q;
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (ridx_i == i2c_regport_pkg::IDX_W'(i)) begin
                rdata_o = flat[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         REG_COUNT = 16,
    parameter logic [5:0] ADDR_HI   = 6'b001100,
    parameter logic [7:0] RST_VAL   = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             strap_i,
    output logic             sda_oe_o,
    output logic             spi_mode_o,
    output logic             wr_stb_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o
);
    port_regs_t q, d;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic spi_mode;
    logic [7:0] rdata;
    logic [7:0] byte_in;
    logic [PTR_W-1:0] ptr_next;
    logic in_range;

    i2c_regport_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_regport_modelatch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .spi_mode_o (spi_mode)
    );

    i2c_regport_bank #(
        .REG_COUNT (REG_COUNT),
        .RST_VAL   (RST_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (q.wr_stb),
        .widx_i  (q.wr_idx),
        .wdata_i (q.wr_data),
        .ridx_i  (q.ptr[IDX_W-1:0]),
        .rdata_o (rdata)
    );

    always_comb begin
        byte_in  = {q.sh[6:0], sda_i};
        ptr_next = q.ptr[PTR_W-1] ? {q.ptr[PTR_W-1], q.ptr[IDX_W-1:0] + IDX_W'(1)} : q.ptr;
        in_range = 32'(q.ptr[IDX_W-1:0]) < REG_COUNT;

        d        = q;
        d.wr_stb = 1'b0;

        if (spi_mode) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = 3'd0;
            d.oe   = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            case (q.kind)
                                K_ADDR: begin
                                    if (byte_in[7:1] == {ADDR_HI, strap_i}) begin
                                        d.rw = byte_in[0];
                                        d.st = ST_ACK;
                                    end else begin
                                        d.st = ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    d.ptr = byte_in;
                                    d.st  = ST_ACK;
                                end
                                default: begin
                                    if (in_range) begin
                                        d.wr_stb  = 1'b1;
                                        d.wr_idx  = q.ptr[IDX_W-1:0];
                                        d.wr_data = byte_in;
                                    end
                                    d.ptr = ptr_next;
                                    d.st  = ST_ACK;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!q.oe) begin
                            d.oe = 1'b1;
                        end else if (q.kind == K_ADDR && q.rw) begin
                            d.st  = ST_TX;
                            d.cnt = 3'd0;
                            d.sh  = rdata;
                            d.oe  = !rdata[7];
                        end else begin
                            d.oe   = 1'b0;
                            d.st   = ST_RX;
                            d.cnt  = 3'd0;
                            d.kind = (q.kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            d.oe  = 1'b0;
                            d.st  = ST_TXACK;
                            d.ptr = ptr_next;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = !q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.st = sda_i ? ST_IDLE : ST_TXLOAD;
                    end
                end
                ST_TXLOAD: begin
                    if (scl_fall) begin
                        d.st  = ST_TX;
                        d.cnt = 3'd0;
                        d.sh  = rdata;
                        d.oe  = !rdata[7];
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_ADDR, cnt: 3'd0, sh: 8'h00, rw: 1'b0,
                   oe: 1'b0, ptr: '0, wr_stb: 1'b0, wr_idx: '0, wr_data: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign spi_mode_o = spi_mode;
    assign wr_stb_o   = q.wr_stb;
    assign wr_idx_o   = q.wr_idx;
    assign wr_data_o  = q.wr_data;
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
    parameter int REG_COUNT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       spi_mode_o,
    input logic       wr_stb_o,
    input logic [6:0] wr_idx_o
);
    // R9: the pull-down enable moves only while SCL is low
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !spi_mode_o) |-> !$past(scl_i));

    // R3: a write strobe lasts a single cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R3: a write strobe is raised while SCL is high after the eighth bit
    a_r3_strobe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> scl_i);

    // R7: no strobe targets an index outside the bank
    a_r7_strobe_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (32'(wr_idx_o) < REG_COUNT));

    // R10: once set, the serial-peripheral flag stays set
    a_r10_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_o |=> spi_mode_o);

    // R10: with the flag settled, the port stays silent
    a_r10_spi_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode_o && $past(spi_mode_o)) |-> (!sda_oe_o && !wr_stb_o));
endmodule

bind i2c_regport i2c_regport_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .spi_mode_o (spi_mode_o),
    .wr_stb_o   (wr_stb_o),
    .wr_idx_o   (wr_idx_o)
);

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;
    localparam int REGS       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic strap = 1'b0;
    logic sda_line;
    logic sda_oe, spi_mode, wr_stb;
    logic [6:0] wr_idx;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [6:0] last_idx = '0;
    logic [7:0] last_data = '0;
    logic [7:0] model [REGS];
    logic [7:0] mptr = 8'h00;
    logic [7:0] wbuf [8];
    bit done = 1'b0;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regport u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe),
        .spi_mode_o (spi_mode),
        .wr_stb_o   (wr_stb),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_idx  = wr_idx;
            last_data = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] adv(input logic [7:0] p);
        return p[7] ? {p[7], p[6:0] + 7'd1} : p;
    endfunction

    function automatic logic [7:0] addr_byte(input logic s, input logic rd);
        return {6'b001100, s, rd};
    endfunction

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        sda_drv = 1'b0; wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q();
        scl = 1'b1;     wait_q();
        sda_drv = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; wait_q();
        scl = 1'b1;  wait_q();
        wait_q();
        scl = 1'b0;  wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        b = sda_line;   wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        acked = !x;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(!give_ack);
    endtask

    task automatic write_regs(input logic [7:0] p, input int n, input string tag);
        int s0;
        int exp_stb;
        logic a;
        logic [6:0] e_idx;
        logic [7:0] e_dat;
        s0 = stb_cnt;
        exp_stb = 0;
        e_idx = '0;
        e_dat = '0;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        chk({tag, " R1 address ack"}, 32'(a), 32'd1);
        send_byte(p, a);
        chk({tag, " R2 pointer ack"}, 32'(a), 32'd1);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk({tag, " R3 data ack"}, 32'(a), 32'd1);
            if (32'(mptr[6:0]) < REGS) begin
                model[mptr[6:0]] = wbuf[i];
                exp_stb++;
                e_idx = mptr[6:0];
                e_dat = wbuf[i];
            end
            mptr = adv(mptr);
        end
        bus_stop();
        wait_q();
        chk({tag, " R3 strobe count"}, 32'(stb_cnt - s0), 32'(exp_stb));
        if (exp_stb > 0) begin
            chk({tag, " R3 strobe index"}, 32'(last_idx), 32'(e_idx));
            chk({tag, " R3 strobe data"}, 32'(last_data), 32'(e_dat));
        end
    endtask

    task automatic read_regs(input int n, input bit set_ptr, input logic [7:0] p, input string tag);
        logic a;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        if (set_ptr) begin
            send_byte(addr_byte(strap, 1'b0), a);
            send_byte(p, a);
            chk({tag, " R2 pointer ack"}, 32'(a), 32'd1);
            mptr = p;
            bus_start();
        end
        send_byte(addr_byte(strap, 1'b1), a);
        chk({tag, " R1 read address ack"}, 32'(a), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            e = (32'(mptr[6:0]) < REGS) ? model[mptr[6:0]] : 8'h00;
            chk({tag, " read data"}, 32'(v), 32'(e));
            mptr = adv(mptr);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        int s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < REGS; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_q();

        // R5: reset state at the ports
        chk("R5 reset oe", 32'(sda_oe), 32'd0);
        chk("R10 reset spi flag", 32'(spi_mode), 32'd0);
        chk("R3 reset strobe", 32'(wr_stb), 32'd0);

        // R5: read before any write sees defaults at pointer 0
        read_regs(2, 1'b0, 8'h00, "R5 default");

        // R4: incrementing write then read back through R6 streaming
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        write_regs(8'h83, 3, "R4 incr write");
        read_regs(3, 1'b1, 8'h83, "R6 incr read");

        // R4: fixed pointer keeps hitting one register
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
        write_regs(8'h07, 2, "R4 fixed write");
        read_regs(2, 1'b1, 8'h07, "R4 fixed read");
        read_regs(1, 1'b1, 8'h08, "R4 neighbour");
        read_regs(1, 1'b0, 8'h00, "R5 current pointer");

        // R7: running past the bank edge
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_regs(8'h8E, 3, "R7 edge write");
        read_regs(3, 1'b1, 8'h8E, "R7 edge read");
        read_regs(1, 1'b1, 8'h45, "R7 far index");

        // R1: wrong address is ignored
        s0 = stb_cnt;
        bus_start();
        send_byte(addr_byte(!strap, 1'b0), a);
        chk("R1 mismatch nack", 32'(a), 32'd0);
        send_byte(8'h02, a);
        chk("R1 ignored byte nack", 32'(a), 32'd0);
        send_byte(8'hFF, a);
        bus_stop();
        wait_q();
        chk("R1 ignored no strobe", 32'(stb_cnt - s0), 32'd0);
        read_regs(1, 1'b1, 8'h03, "R1 contents kept");

        // R8: repeated START in the middle of a data byte
        s0 = stb_cnt;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h84, a);
        chk("R8 pointer ack", 32'(a), 32'd1);
        mptr = 8'h84;
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk("R8 restart address ack", 32'(a), 32'd1);
        recv_byte(1'b0, wbuf[0]);
        chk("R8 read after abort", 32'(wbuf[0]), 32'(model[4]));
        bus_stop();
        wait_q();
        chk("R8 aborted byte not written", 32'(stb_cnt - s0), 32'd0);

        // R3: random transfers against the model
        for (int it = 0; it < 24; it++) begin
            logic [7:0] p;
            int n;
            p = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 19))};
            n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
            write_regs(p, n, "R3 random write");
            read_regs(n, 1'b1, p, "R3 random read");
        end

        // R1: strap level supplies the low address bit
        strap = 1'b1;
        wait_q();
        chk("R10 rising strap no effect", 32'(spi_mode), 32'd0);
        wbuf[0] = 8'h3C;
        write_regs(8'h02, 1, "R1 strap high write");
        read_regs(1, 1'b1, 8'h02, "R1 strap high read");

        // R10: falling strap takes the port off the bus
        strap = 1'b0;
        wait_q();
        chk("R10 spi flag set", 32'(spi_mode), 32'd1);
        s0 = stb_cnt;
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), a);
        chk("R10 no ack in spi mode", 32'(a), 32'd0);
        send_byte(8'h02, a);
        send_byte(8'h99, a);
        bus_stop();
        wait_q();
        chk("R10 no write in spi mode", 32'(stb_cnt - s0), 32'd0);
        strap = 1'b1;
        wait_q();
        chk("R10 spi flag sticky", 32'(spi_mode), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule